// File: doc/BRIEF.md
# Hot Path Accumulation Table

This block keeps a profile of the program paths that carry the most weight. A path arrives as a descriptor (start address, branch count and one outcome bit per branch) together with a count. The count may be a plain occurrence of one, or a weight such as the number of events seen along the path. The table is set-associative. A hash of the descriptor selects one set. If a valid way in that set holds the same descriptor, the count is added to that way's accumulator. If no way matches, the way with the smallest accumulator is replaced, so that the heaviest paths stay resident.

Descriptors enter through a valid/ready stream. A hit is absorbed in the cycle it is accepted. A miss starts a staged tree comparison over the accumulators of the set. During that search the input is back-pressured, and the new entry is written at the end. A plain `clear` level empties the table. A combinational readout port lets software step through every entry to dump the profile.

Top module: `hot_path_table`

## Requirements
- R1: After reset every entry reads back invalid and `in_ready` is high.
- R2: The set index is `in_addr[2 +: IDX_W] ^ in_len (zero-extended or truncated to IDX_W) ^ in_outc[IDX_W-1:0]`, where IDX_W = log2(SETS). Entry number `set*WAYS + way` is the index used on `rd_idx`.
- R3: A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. If a valid way of the indexed set matches address, length and outcomes exactly, `in_count` is added to that way's accumulator at that edge, and `in_ready` stays high in the following cycle unless `clear` is high.
- R4: An accumulator that would pass 2^ACC_W-1 holds at 2^ACC_W-1 and does not wrap.
- R5: After a transfer that misses, `in_ready` is low for exactly log2(WAYS) cycles. The descriptor is installed at the last edge of that window with its accumulator equal to the transferred count.
- R6: On a miss, an invalid way is chosen before any valid way, and among invalid ways the lowest-numbered one is chosen.
- R7: If all ways of the set are valid, the way with the smallest accumulator is replaced, and ties go to the lowest-numbered way.
- R8: While `clear` is high, `in_ready` is low. At the edge where `clear` is high, every entry becomes invalid and any miss still being resolved is dropped.
- R9: `rd_valid`, `rd_addr`, `rd_len`, `rd_outc` and `rd_acc` show the entry selected by `rd_idx` in the same cycle, without a clock edge.
- R10: A cycle without a transfer, without a pending miss and without `clear` leaves every entry unchanged, whatever the descriptor inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Invalidate all entries, abort a pending miss |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Table can take a descriptor |
| in_addr | input | ADDR_W | Path start address |
| in_len | input | LEN_W | Number of branches on the path |
| in_outc | input | OUT_W | Branch outcome bits |
| in_count | input | CNT_W | Weight added for this path |
| rd_idx | input | ENT_W | Entry number to read out |
| rd_valid | output | 1 | Selected entry holds a path |
| rd_addr | output | ADDR_W | Stored start address |
| rd_len | output | LEN_W | Stored branch count |
| rd_outc | output | OUT_W | Stored outcome bits |
| rd_acc | output | ACC_W | Stored accumulator |

## Verification
The assertions assume that the source follows the valid/ready rule: a descriptor that is offered while `in_ready` is low is taken as not yet transferred. They also assume that `clear` is a synchronous level sampled on the same edge as the stream, and that the tree search is only started while it is idle. They do not require the descriptor fields to stay stable. The bench drives every input half a period away from the rising edge. It holds each offered descriptor until it is accepted, and it raises `clear` during a search to exercise the abort path. It also steers descriptors into one set so that filling invalid ways, breaking ties and evicting the lightest way all happen in a known order.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  typedef enum logic {
    LOOK_FREE = 1'b0,
    LOOK_BUSY = 1'b1
  } hpt_look_e;
endpackage

// File: rtl/hpt_set_hash.sv
module hpt_set_hash #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int OUT_W  = 32,
  parameter int IDX_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [OUT_W-1:0]  outc,
  output logic [IDX_W-1:0]  set_idx
);
  // R2: fold word address bits with length and outcome bits
  always_comb begin
    set_idx = addr[2 +: IDX_W] ^ IDX_W'(len) ^ outc[IDX_W-1:0];
  end
endmodule

// File: rtl/hpt_victim_tree.sv
module hpt_victim_tree #(
  parameter int WAYS  = 4,
  parameter int KEY_W = 33,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        start,
  input  logic [WAYS-1:0][KEY_W-1:0]  keys_in,
  output logic                        busy,
  output logic                        done,
  output logic [WAY_W-1:0]            victim
);
  import hpt_pkg::*;
  localparam int LVLS  = $clog2(WAYS);
  localparam int HALF  = WAYS / 2;
  localparam int STG_W = (LVLS > 1) ? $clog2(LVLS) : 1;

  logic [KEY_W-1:0] key_q  [WAYS];
  logic [WAY_W-1:0] way_q  [WAYS];
  logic [KEY_W-1:0] nkey   [HALF];
  logic [WAY_W-1:0] nway   [HALF];
  logic [STG_W-1:0] stage_q;
  hpt_look_e        st_q;

  // one tree level per cycle; the left (lower) way keeps ties (R7)
  for (genvar i = 0; i < HALF; i++) begin : g_pair
    logic take_r;
    assign take_r  = key_q[2*i+1] < key_q[2*i];
    assign nkey[i] = take_r ? key_q[2*i+1] : key_q[2*i];
    assign nway[i] = take_r ? way_q[2*i+1] : way_q[2*i];
  end

  assign busy   = (st_q == LOOK_BUSY);
  assign done   = busy && (stage_q == STG_W'(LVLS - 1));
  assign victim = nway[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LOOK_FREE;
      stage_q <= '0;
    end else if (flush) begin
      st_q    <= LOOK_FREE;
      stage_q <= '0;
    end else if (start) begin
      st_q    <= LOOK_BUSY;
      stage_q <= '0;
    end else if (busy) begin
      if (done) st_q <= LOOK_FREE;
      else      stage_q <= stage_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      for (int w = 0; w < WAYS; w++) begin
        key_q[w] <= keys_in[w];
        way_q[w] <= WAY_W'(w);
      end
    end else if (busy) begin
      for (int i = 0; i < HALF; i++) begin
        key_q[i] <= nkey[i];
        way_q[i] <= nway[i];
      end
    end
  end

  // R5: a new search is only launched once the previous one has ended
  a_r5_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/hot_path_table.sv
module hot_path_table #(
  parameter int SETS   = 128,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int OUT_W  = 32,
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 32,
  localparam int ENTRIES = SETS * WAYS,
  localparam int ENT_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [OUT_W-1:0]  in_outc,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [ENT_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic [OUT_W-1:0]  rd_outc,
  output logic [ACC_W-1:0]  rd_acc
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int KEY_W = ACC_W + 1;

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [LEN_W-1:0]   ent_len  [ENTRIES];
  logic [OUT_W-1:0]   ent_outc [ENTRIES];
  logic [ACC_W-1:0]   ent_acc  [ENTRIES];

  logic [IDX_W-1:0]   set_idx;
  logic               hit;
  logic [WAY_W-1:0]   hit_way;
  logic [ENT_W-1:0]   hit_ent;
  logic [ACC_W:0]     sum;
  logic [ACC_W-1:0]   sum_sat;
  logic [WAYS-1:0][KEY_W-1:0] keys;
  logic               accept, start, t_busy, t_done;
  logic [WAY_W-1:0]   t_victim;

  logic [IDX_W-1:0]   p_set;
  logic [ADDR_W-1:0]  p_addr;
  logic [LEN_W-1:0]   p_len;
  logic [OUT_W-1:0]   p_outc;
  logic [CNT_W-1:0]   p_cnt;
  logic [ENT_W-1:0]   ins_ent;

  hpt_set_hash #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OUT_W(OUT_W), .IDX_W(IDX_W)) u_hash (
    .addr(in_addr), .len(in_len), .outc(in_outc), .set_idx(set_idx));

  // R3: tag compare across the indexed set
  always_comb begin
    logic [ENT_W-1:0] e;
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      e = {set_idx, WAY_W'(w)};
      if (valid_q[e] && ent_addr[e] == in_addr && ent_len[e] == in_len &&
          ent_outc[e] == in_outc) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // R6/R7: invalid ways rank below every valid way
  always_comb begin
    logic [ENT_W-1:0] e;
    for (int w = 0; w < WAYS; w++) begin
      e       = {set_idx, WAY_W'(w)};
      keys[w] = valid_q[e] ? {1'b1, ent_acc[e]} : '0;
    end
  end

  assign hit_ent = {set_idx, hit_way};
  assign sum     = {1'b0, ent_acc[hit_ent]} + (ACC_W+1)'(in_count);
  assign sum_sat = sum[ACC_W] ? '1 : sum[ACC_W-1:0];   // R4
  assign in_ready = !t_busy && !clear;
  assign accept   = in_valid && in_ready;
  assign start    = accept && !hit;
  assign ins_ent  = {p_set, t_victim};

  hpt_victim_tree #(.WAYS(WAYS), .KEY_W(KEY_W), .WAY_W(WAY_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .flush(clear), .start(start), .keys_in(keys),
    .busy(t_busy), .done(t_done), .victim(t_victim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                valid_q <= '0;
    else if (clear)            valid_q <= '0;
    else if (t_done)           valid_q[ins_ent] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (start) begin
      p_set  <= set_idx;
      p_addr <= in_addr;
      p_len  <= in_len;
      p_outc <= in_outc;
      p_cnt  <= in_count;
    end
    if (accept && hit) begin
      ent_acc[hit_ent] <= sum_sat;
    end else if (t_done && !clear) begin
      ent_addr[ins_ent] <= p_addr;
      ent_len[ins_ent]  <= p_len;
      ent_outc[ins_ent] <= p_outc;
      ent_acc[ins_ent]  <= ACC_W'(p_cnt);
    end
  end

  assign rd_valid = valid_q[rd_idx];   // R9
  assign rd_addr  = ent_addr[rd_idx];
  assign rd_len   = ent_len[rd_idx];
  assign rd_outc  = ent_outc[rd_idx];
  assign rd_acc   = ent_acc[rd_idx];

  a_r5_miss_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> !in_ready);
  a_r3_hit_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (in_ready || clear));
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !rd_valid);
  a_r10_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !t_busy && !clear) |=> $stable(valid_q));
endmodule

// File: tb/hot_path_table_test.sv
module hot_path_table_test;
  localparam int SETS = 128, WAYS = 4, ADDR_W = 32, LEN_W = 6, OUT_W = 32;
  localparam int CNT_W = 8, ACC_W = 12;
  localparam int ENTRIES = SETS * WAYS;
  localparam int ENT_W = $clog2(ENTRIES);
  localparam int IDX_W = $clog2(SETS);
  localparam int LVLS = $clog2(WAYS);
  localparam int ACC_MAX = (1 << ACC_W) - 1;

  logic clk = 0, rst_n = 0, clear = 0, in_valid = 0;
  logic in_ready, rd_valid;
  logic [ADDR_W-1:0] in_addr = '0, rd_addr;
  logic [LEN_W-1:0]  in_len = '0, rd_len;
  logic [OUT_W-1:0]  in_outc = '0, rd_outc;
  logic [CNT_W-1:0]  in_count = '0;
  logic [ENT_W-1:0]  rd_idx = '0;
  logic [ACC_W-1:0]  rd_acc;

  always #10 clk = ~clk;

  hot_path_table #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .OUT_W(OUT_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len(in_len), .in_outc(in_outc), .in_count(in_count),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_outc(rd_outc), .rd_acc(rd_acc));

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";
  int sweep = 0;

  bit                m_val  [ENTRIES];
  logic [ADDR_W-1:0] m_addr [ENTRIES];
  logic [LEN_W-1:0]  m_len  [ENTRIES];
  logic [OUT_W-1:0]  m_outc [ENTRIES];
  int                m_acc  [ENTRIES];
  int m_pend = 0, p_ent = 0, p_cnt = 0;
  logic [ADDR_W-1:0] p_addr;
  logic [LEN_W-1:0]  p_len;
  logic [OUT_W-1:0]  p_outc;

  function automatic int set_of(logic [ADDR_W-1:0] a, logic [LEN_W-1:0] l, logic [OUT_W-1:0] o);
    logic [IDX_W-1:0] s;
    s = a[2 +: IDX_W] ^ IDX_W'(l) ^ o[IDX_W-1:0];
    return int'(s);
  endfunction

  task automatic chk(bit ok, string t, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic compare_entry(string t);
    int i;
    i = int'(rd_idx);
    chk(rd_valid == m_val[i], t, "rd_valid", rd_valid, m_val[i]);
    if (m_val[i]) begin
      chk(rd_addr == m_addr[i], t, "rd_addr", rd_addr, m_addr[i]);
      chk(rd_len == m_len[i], t, "rd_len", rd_len, m_len[i]);
      chk(rd_outc == m_outc[i], t, "rd_outc", rd_outc, m_outc[i]);
      chk(int'(rd_acc) == m_acc[i], t, "rd_acc", rd_acc, m_acc[i]);
    end
  endtask

  task automatic model_edge();
    int s, hw, v, best;
    if (clear) begin
      for (int i = 0; i < ENTRIES; i++) m_val[i] = 0;
      m_pend = 0;
    end else if (m_pend > 0) begin
      m_pend--;
      if (m_pend == 0) begin
        m_val[p_ent] = 1; m_addr[p_ent] = p_addr; m_len[p_ent] = p_len;
        m_outc[p_ent] = p_outc; m_acc[p_ent] = p_cnt;
      end
    end else if (in_valid) begin
      s = set_of(in_addr, in_len, in_outc);
      hw = -1;
      for (int w = 0; w < WAYS; w++)
        if (m_val[s*WAYS+w] && m_addr[s*WAYS+w] == in_addr && m_len[s*WAYS+w] == in_len &&
            m_outc[s*WAYS+w] == in_outc) hw = w;
      if (hw >= 0) begin
        m_acc[s*WAYS+hw] = m_acc[s*WAYS+hw] + int'(in_count);
        if (m_acc[s*WAYS+hw] > ACC_MAX) m_acc[s*WAYS+hw] = ACC_MAX;
      end else begin
        v = -1;
        for (int w = WAYS-1; w >= 0; w--) if (!m_val[s*WAYS+w]) v = w;
        if (v < 0) begin
          v = 0; best = m_acc[s*WAYS];
          for (int w = 1; w < WAYS; w++)
            if (m_acc[s*WAYS+w] < best) begin best = m_acc[s*WAYS+w]; v = w; end
        end
        p_ent = s*WAYS + v; p_addr = in_addr; p_len = in_len; p_outc = in_outc;
        p_cnt = int'(in_count); m_pend = LVLS;
      end
    end
  endtask

  task automatic cycle(bit v, logic [ADDR_W-1:0] a, logic [LEN_W-1:0] l,
                       logic [OUT_W-1:0] o, logic [CNT_W-1:0] c, bit clr, output bit took);
    bit exp_rdy;
    in_valid = v; in_addr = a; in_len = l; in_outc = o; in_count = c; clear = clr;
    rd_idx = ENT_W'(sweep); sweep = (sweep + 1) % ENTRIES;
    #1;
    exp_rdy = (m_pend == 0) && !clr;
    chk(in_ready == exp_rdy, tag, "in_ready", in_ready, exp_rdy);
    compare_entry(tag);
    took = v && exp_rdy;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; clear = 0;
  endtask

  task automatic send(logic [ADDR_W-1:0] a, logic [LEN_W-1:0] l, logic [OUT_W-1:0] o,
                      logic [CNT_W-1:0] c);
    bit took;
    took = 0;
    while (!took) cycle(1, a, l, o, c, 0, took);
  endtask

  task automatic idle(int n);
    bit took;
    repeat (n) cycle(0, '0, '0, '0, '0, 0, took);
  endtask

  task automatic peek(int idx, string t);
    rd_idx = ENT_W'(idx);
    #1;
    compare_entry(t);
  endtask

  task automatic lit(int idx, logic [ADDR_W-1:0] ea, int eacc, string t);
    rd_idx = ENT_W'(idx);
    #1;
    chk(rd_valid == 1'b1, t, "literal valid", rd_valid, 1);
    chk(rd_addr == ea, t, "literal addr", rd_addr, ea);
    chk(int'(rd_acc) == eacc, t, "literal acc", rd_acc, eacc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit took;
    int e, k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    tag = "R1";
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    for (int i = 0; i < ENTRIES; i++) peek(i, "R1");

    // R2/R3/R9: install then accumulate hits
    tag = "R3";
    send(32'h100, 6'd5, 32'h3, 8'd7);
    idle(2);
    send(32'h100, 6'd5, 32'h3, 8'd10);
    send(32'h100, 6'd5, 32'h3, 8'd20);
    send(32'h100, 6'd5, 32'h3, 8'd30);
    idle(1);
    e = set_of(32'h100, 6'd5, 32'h3) * WAYS;
    lit(e, 32'h100, 67, "R2");
    lit(e, 32'h100, 67, "R9");

    // R4: saturation
    tag = "R4";
    for (int i = 0; i < 20; i++) send(32'h2000, 6'd1, 32'h1, 8'd255);
    idle(2);
    lit(set_of(32'h2000, 6'd1, 32'h1) * WAYS, 32'h2000, ACC_MAX, "R4");

    // R5/R6: fill set 9 in way order; ready low for LVLS cycles after each miss
    tag = "R5";
    send((32'd1 << 12) | (32'd9 << 2), '0, '0, 8'd50);
    for (int i = 0; i < LVLS; i++) begin
      cycle(0, '0, '0, '0, '0, 0, took);
    end
    chk(in_ready == 1'b1, "R5", "ready back after search", in_ready, 1);
    tag = "R6";
    send((32'd2 << 12) | (32'd9 << 2), '0, '0, 8'd30);
    send((32'd3 << 12) | (32'd9 << 2), '0, '0, 8'd30);
    send((32'd4 << 12) | (32'd9 << 2), '0, '0, 8'd60);
    idle(LVLS);
    for (int w = 0; w < WAYS; w++) lit(36 + w, ((w + 1) << 12) | (9 << 2), (w == 0) ? 50 : (w == 3) ? 60 : 30, "R6");

    // R7: tie between ways 1 and 2 goes to way 1, then the lightest is replaced
    tag = "R7";
    send((32'd5 << 12) | (32'd9 << 2), '0, '0, 8'd1);
    idle(LVLS);
    lit(37, (32'd5 << 12) | (32'd9 << 2), 1, "R7");
    lit(38, (32'd3 << 12) | (32'd9 << 2), 30, "R7");
    send((32'd6 << 12) | (32'd9 << 2), '0, '0, 8'd2);
    idle(LVLS);
    lit(37, (32'd6 << 12) | (32'd9 << 2), 2, "R7");

    // R10: descriptor inputs wiggle without valid
    tag = "R10";
    for (int i = 0; i < 8; i++) cycle(0, (32'd7 << 12) | (32'd9 << 2), 6'(i), 32'(i), 8'd9, 0, took);
    for (int w = 0; w < WAYS; w++) peek(36 + w, "R10");

    // random traffic over a small pool of colliding descriptors
    tag = "R7";
    for (int i = 0; i < 600; i++) begin
      k = int'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) idle(1);
      else send(((k + 1) << 12) | ((3 + k % 2) << 2), '0, 32'(k % 4 == 0 ? 4 : 0),
                8'($urandom_range(1, 255)));
    end
    idle(LVLS);
    for (int s = 0; s < 8; s++) for (int w = 0; w < WAYS; w++) peek(s * WAYS + w, "R7");

    // R8: clear while a miss is being searched
    tag = "R8";
    send(32'h0005_0040, 6'd2, 32'h0, 8'd11);
    cycle(0, '0, '0, '0, '0, 1, took);
    idle(LVLS + 1);
    for (int i = 0; i < ENTRIES; i++) peek(i, "R8");
    send(32'h0005_0040, 6'd2, 32'h0, 8'd11);
    idle(LVLS);
    lit(set_of(32'h0005_0040, 6'd2, 32'h0) * WAYS, 32'h0005_0040, 11, "R8");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule